// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers interrupt requests from a set of devices and turns them into one interrupt line towards the processor, together with a vector number. Each device carries a fixed priority, given as a parameter. The defaults are device 0 (clock) at 5, device 1 (keyboard) at 4, device 2 (screen) at 4 and device 3 at 2. A request is offered to the processor only when its priority is strictly above the priority the processor is currently running at. The vector number is the device number itself.

Requests are latched as pending. When the processor takes an interrupt (`ack_i` while `irq_o` is high), the device moves to an in-service set. Pending requests of equal or lower priority are then held back until the processor signals end of service on `eoi_i`. A strictly higher priority request may still nest on top of the running handler. End of service retires the highest-priority in-service device. After that the waiting devices are evaluated again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0 and `vec_o` is 0, with no device pending and none in service.
- R2: A device is presented only when its priority is strictly greater than `cpu_prio_i`. A change of `cpu_prio_i` is reflected on `irq_o` one clock edge later.
- R3: Among eligible devices, the one with the highest priority is presented, and `vec_o` equals its device number (0 to NUM_DEV-1).
- R4: Among eligible devices of equal priority, the lowest device number wins.
- R5: Outputs are registered. A request driven before clock edge k appears on `irq_o` at edge k+1 and not at edge k.
- R6: Requests are level-sensitive and latched. A one-cycle request pulse stays pending until it is accepted. A request still held high after its end of service is presented again.
- R7: `ack_i` while `irq_o` is 1 accepts the vector on `vec_o`. That device enters service, its pending bit clears and `irq_o` is 0 after the next edge. `ack_i` while `irq_o` is 0 has no effect.
- R8: While devices are in service, a pending device is presented only if its priority is strictly greater than the highest in-service priority.
- R9: A request of higher priority than every in-service device and the CPU priority is presented while a handler is running (nesting).
- R10: `eoi_i` removes the highest-priority in-service device, after which waiting devices are evaluated again. With nothing in service, `eoi_i` is ignored.
- R11: `ack_i` (with `irq_o` high) and `eoi_i` in the same cycle both take effect. The end of service retires the device that was in service before the accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | NUM_DEV | Level request per device, bit i = device i |
| cpu_prio_i | input | PRIO_W | Current processor priority |
| ack_i | input | 1 | Processor accepts the presented interrupt |
| eoi_i | input | 1 | Processor signals end of the current handler |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Vector number = selected device number |

## Verification
Acceptance of a new interrupt and end of service of the previous one can land on the same edge. One acts on the in-service set by adding the presented device, the other by removing the top entry. The bench provokes this by nesting device 0 over an in-service device 1 and pulsing `ack_i` and `eoi_i` together. It then judges the outcome from the ports: the waiting equal-priority device 2 must stay blocked until one further end of service, and must appear right after it. If either action were lost, device 2 would appear too early or never.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DEF_NUM_DEV = 4;
  localparam int unsigned DEF_PRIO_W  = 3;
  // device 3..0 : 2, 4, 4, 5
  localparam logic [DEF_NUM_DEV*DEF_PRIO_W-1:0] DEF_DEV_PRIO = {3'd2, 3'd4, 3'd4, 3'd5};

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_pick.sv
// Highest priority among masked devices, lowest index on ties.
module irq_pick #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned VEC_W   = 2
) (
  input  logic [NUM_DEV-1:0]        mask_i,
  input  logic [NUM_DEV*PRIO_W-1:0] prio_i,
  output logic                      found_o,
  output logic [VEC_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (mask_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
        found_o = 1'b1;
        idx_o   = VEC_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_elig.sv
// Per-device eligibility: pending, not in service, above CPU and in-service ceiling.
module irq_elig #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic [NUM_DEV-1:0]        pend_i,
  input  logic [NUM_DEV-1:0]        isr_i,
  input  logic [NUM_DEV*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         cpu_prio_i,
  input  logic                      isr_any_i,
  input  logic [PRIO_W-1:0]         isr_top_i,
  output logic [NUM_DEV-1:0]        elig_o
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic [PRIO_W-1:0] p;
    assign p = prio_i[g*PRIO_W +: PRIO_W];
    assign elig_o[g] = pend_i[g] && !isr_i[g] && (p > cpu_prio_i) &&
                       (!isr_any_i || (p > isr_top_i));
  end
endmodule

// File: rtl/irq_track.sv
// Pending and in-service state.
module irq_track #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned VEC_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] req_i,
  input  logic               take_i,
  input  logic [VEC_W-1:0]   take_idx_i,
  input  logic               retire_i,
  input  logic [VEC_W-1:0]   retire_idx_i,
  output logic [NUM_DEV-1:0] pend_o,
  output logic [NUM_DEV-1:0] isr_o
);
  logic [NUM_DEV-1:0] take_mask, retire_mask;
  logic [NUM_DEV-1:0] pend_q, isr_q;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_mask
    assign take_mask[g]   = take_i   && (take_idx_i   == VEC_W'(g));
    assign retire_mask[g] = retire_i && (retire_idx_i == VEC_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take_mask) | req_i;
      isr_q  <= (isr_q & ~retire_mask) | take_mask;
    end
  end

  assign pend_o = pend_q;
  assign isr_o  = isr_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned NUM_DEV = irq_pkg::DEF_NUM_DEV,
  parameter int unsigned PRIO_W  = irq_pkg::DEF_PRIO_W,
  parameter logic [NUM_DEV*PRIO_W-1:0] DEV_PRIO = irq_pkg::DEF_DEV_PRIO,
  localparam int unsigned VEC_W  = irq_pkg::idx_width(NUM_DEV)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] dev_req_i,
  input  logic [PRIO_W-1:0]  cpu_prio_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [NUM_DEV-1:0] pend_q, isr_q, elig;
  logic               isr_any, win_found;
  logic [VEC_W-1:0]   isr_idx, win_idx;
  logic [PRIO_W-1:0]  isr_top, win_prio;
  logic               irq_q, accept, retire;
  logic [VEC_W-1:0]   vec_q;

  assign accept = ack_i && irq_q;
  assign retire = eoi_i && isr_any;

  irq_track #(.NUM_DEV(NUM_DEV), .VEC_W(VEC_W)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (dev_req_i),
    .take_i       (accept),
    .take_idx_i   (vec_q),
    .retire_i     (retire),
    .retire_idx_i (isr_idx),
    .pend_o       (pend_q),
    .isr_o        (isr_q)
  );

  // top of the in-service set
  irq_pick #(.NUM_DEV(NUM_DEV), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_isr_pick (
    .mask_i  (isr_q),
    .prio_i  (DEV_PRIO),
    .found_o (isr_any),
    .idx_o   (isr_idx),
    .prio_o  (isr_top)
  );

  irq_elig #(.NUM_DEV(NUM_DEV), .PRIO_W(PRIO_W)) u_elig (
    .pend_i     (pend_q),
    .isr_i      (isr_q),
    .prio_i     (DEV_PRIO),
    .cpu_prio_i (cpu_prio_i),
    .isr_any_i  (isr_any),
    .isr_top_i  (isr_top),
    .elig_o     (elig)
  );

  irq_pick #(.NUM_DEV(NUM_DEV), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_win_pick (
    .mask_i  (elig),
    .prio_i  (DEV_PRIO),
    .found_o (win_found),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  // the accepted vector is dropped for one cycle while state settles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= win_found && !accept;
      if (win_found && !accept) vec_q <= win_idx;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned PRIO_W  = 3,
  parameter logic [NUM_DEV*PRIO_W-1:0] DEV_PRIO = '0,
  parameter int unsigned VEC_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PRIO_W-1:0]  cpu_prio_i,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [NUM_DEV-1:0] isr_q
);
  logic              isr_any;
  logic [PRIO_W-1:0] isr_top;
  logic [PRIO_W-1:0] vec_prio;

  always_comb begin
    isr_any = 1'b0;
    isr_top = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (isr_q[i] && (!isr_any || DEV_PRIO[i*PRIO_W +: PRIO_W] > isr_top)) begin
        isr_any = 1'b1;
        isr_top = DEV_PRIO[i*PRIO_W +: PRIO_W];
      end
    end
    vec_prio = DEV_PRIO[vec_o*PRIO_W +: PRIO_W];
  end

  a_r2_above_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> vec_prio > $past(cpu_prio_i));

  a_r3_vec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int'(vec_o) < NUM_DEV);

  a_r7_accept_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> (!irq_o && isr_q[$past(vec_o)]));

  a_r7_idle_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && ack_i && !eoi_i) |=> isr_q == $past(isr_q));

  a_r8_above_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!$past(isr_any) || vec_prio > $past(isr_top)));

  a_r10_eoi_retires_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_any && !(irq_o && ack_i)) |=>
      $countones(isr_q) == $past($countones(isr_q)) - 1);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NUM_DEV(NUM_DEV), .PRIO_W(PRIO_W), .DEV_PRIO(DEV_PRIO), .VEC_W(VEC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_prio_i (cpu_prio_i),
  .ack_i      (ack_i),
  .eoi_i      (eoi_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .isr_q      (isr_q)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int unsigned N  = irq_pkg::DEF_NUM_DEV;
  localparam int unsigned PW = irq_pkg::DEF_PRIO_W;
  localparam int unsigned VW = irq_pkg::idx_width(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  dev_req_i = '0;
  logic [PW-1:0] cpu_prio_i = '0;
  logic          ack_i = 1'b0;
  logic          eoi_i = 1'b0;
  logic          irq_o;
  logic [VW-1:0] vec_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .dev_req_i(dev_req_i), .cpu_prio_i(cpu_prio_i),
    .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o), .vec_o(vec_o)
  );

  function automatic int prio_of(int d);
    return int'(irq_pkg::DEF_DEV_PRIO[d*PW +: PW]);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; dev_req_i = '0; cpu_prio_i = '0; ack_i = 1'b0; eoi_i = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic pulse_req(logic [N-1:0] m);
    dev_req_i = m; tick(); dev_req_i = '0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    check("R1 irq", int'(irq_o), 0);
    check("R1 vec", int'(vec_o), 0);

    // single device against every CPU priority
    for (int d = 0; d < int'(N); d++) begin
      for (int c = 0; c < (1 << PW); c++) begin
        do_reset();
        cpu_prio_i = PW'(c);
        pulse_req(N'(1) << d);
        check("R5 not yet", int'(irq_o), 0);
        tick();
        check("R2/R6 gate", int'(irq_o), (prio_of(d) > c) ? 1 : 0);
        if (prio_of(d) > c) check("R3 vec", int'(vec_o), d);
      end
    end

    // every pair: highest wins, ties to lower number
    for (int a = 0; a < int'(N); a++) begin
      for (int b = 0; b < int'(N); b++) begin
        if (a != b) begin
          int w;
          do_reset();
          pulse_req((N'(1) << a) | (N'(1) << b));
          tick();
          if (prio_of(a) > prio_of(b)) w = a;
          else if (prio_of(b) > prio_of(a)) w = b;
          else w = (a < b) ? a : b;
          check("R3/R4 pair", int'(vec_o), w);
          check("R3 pair irq", int'(irq_o), 1);
        end
      end
    end

    // service sequence
    do_reset();
    pulse_req(N'(6)); tick();
    check("R4 vec", int'(vec_o), 1);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    check("R7 drop", int'(irq_o), 0);
    tick();
    check("R8 equal blocked", int'(irq_o), 0);
    tick();
    check("R8 still blocked", int'(irq_o), 0);
    pulse_req(N'(1)); tick();
    check("R9 nest irq", int'(irq_o), 1);
    check("R9 nest vec", int'(vec_o), 0);
    ack_i = 1'b1; eoi_i = 1'b1; tick(); ack_i = 1'b0; eoi_i = 1'b0;
    check("R11 drop", int'(irq_o), 0);
    tick();
    check("R11 dev2 blocked by dev0", int'(irq_o), 0);
    eoi_i = 1'b1; tick(); eoi_i = 1'b0;
    tick();
    check("R10/R11 next irq", int'(irq_o), 1);
    check("R10/R11 next vec", int'(vec_o), 2);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    eoi_i = 1'b1; tick(); eoi_i = 1'b0;
    tick();
    check("R10 none left", int'(irq_o), 0);
    // idle ack and idle eoi must not touch state
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    eoi_i = 1'b1; tick(); eoi_i = 1'b0;
    pulse_req(N'(8)); tick();
    check("R7 idle ack irq", int'(irq_o), 1);
    check("R7 idle ack vec", int'(vec_o), 3);
    cpu_prio_i = PW'(2); tick();
    check("R2 equal cpu", int'(irq_o), 0);
    cpu_prio_i = PW'(1); tick();
    check("R2 lower cpu", int'(irq_o), 1);

    // level request held through service is offered again
    do_reset();
    dev_req_i = N'(4); tick(); tick();
    check("R6 level vec", int'(vec_o), 2);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    eoi_i = 1'b1; tick(); eoi_i = 1'b0;
    tick();
    check("R6 level again irq", int'(irq_o), 1);
    check("R6 level again vec", int'(vec_o), 2);
    dev_req_i = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule